// File: doc/BRIEF.md
# Misaligned Load/Store Line Splitter

This block sits between one load/store requester and two line-wide memory ports. A request names a start address and a byte count from 1 to 16. The bytes it covers may fall inside one 16-byte line or run over into the next line. The block works out which bytes of each line are touched and sends each line's share to the port that owns that line. One port always serves lines whose line number is even, and the other always serves odd lines.

For a store, the block moves the requester's right-aligned write data into byte position in both lines. For a load, it collects the two returned lines, which may arrive in different cycles. It keeps only the requested bytes and hands them back right-aligned. The requester sees a single handshake: busy, one address-accepted pulse, one exception pulse, and one load-data pulse. These are combined from the handshakes of both halves.

Top module: `ls_line_splitter`

## Requirements
- R1: Port p serves only lines whose line number (address bits [ADDR_W-1:4]) has bit 0 equal to p. The span mask is ((1<<len)-1) << address[3:0], 32 bits wide. The port that owns line address[ADDR_W-1:4] gets bits [15:0] of that mask on `dn_mask_o`, with bit k enabling byte k of the line. The other port gets bits [31:16] for the following line (line number plus one, with carry).
- R2: A port whose 16-bit mask is all zero raises none of its load request, store request or address-valid outputs for the whole request.
- R3: After reset, busy is low. With no request pending, busy is high in the same cycle a load or store request appears, and it stays high until the request ends.
- R4: Upstream address-accepted is a one-cycle pulse, given once per request. It appears in the first cycle in which every active half has had its address accepted, and never earlier.
- R5: An address exception from any active half gives one upstream exception pulse in the same cycle, with busy low in that cycle. No outgoing request line is high in the next cycle.
- R6: For a load, the result byte i (for i < len) equals memory byte address+i, and result bytes at i >= len are zero. The result is given with a single data-valid pulse. That pulse comes only after the upstream address-accepted pulse and once every active half has returned its line, even if the two halves return in different cycles. Busy is low in that same cycle.
- R7: A store-valid pulse from the requester, given after address-accepted, drives store-valid on every active port in that same cycle. Each enabled byte at memory address a carries source byte a-address. Busy is high in the pulse cycle and low in the cycle after it.
- R8: A port's load request falls in the cycle after that port returns its load data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_ld_i | input | 1 | Load request from the requester |
| up_st_i | input | 1 | Store request from the requester |
| up_len_i | input | 5 | Byte count, 1 to 16 |
| up_addr_i | input | ADDR_W | Byte start address |
| up_addr_vld_i | input | 1 | Start address is valid |
| up_busy_o | output | 1 | Request in progress |
| up_addr_ack_o | output | 1 | Address accepted (one-cycle pulse) |
| up_addr_exc_o | output | 1 | Address exception (one-cycle pulse) |
| up_ld_data_o | output | 128 | Right-aligned load result |
| up_ld_vld_o | output | 1 | Load result valid (one-cycle pulse) |
| up_st_data_i | input | 128 | Right-aligned store data |
| up_st_vld_i | input | 1 | Store data valid (one-cycle pulse) |
| dn_ld_o | output | 2 | Per-port load request |
| dn_st_o | output | 2 | Per-port store request |
| dn_addr_vld_o | output | 2 | Per-port line address valid |
| dn_line_o | output | 2x(ADDR_W-4) | Per-port line number |
| dn_mask_o | output | 2x16 | Per-port byte enables |
| dn_addr_ack_i | input | 2 | Per-port address accepted pulse |
| dn_addr_exc_i | input | 2 | Per-port address exception pulse |
| dn_ld_data_i | input | 2x128 | Per-port returned line |
| dn_ld_vld_i | input | 2 | Per-port load data valid pulse |
| dn_st_data_o | output | 2x128 | Per-port positioned store data |
| dn_st_vld_o | output | 2 | Per-port store data valid |

## Verification
Two functions can land in the same cycle. The first is the return of one half's load line. The second is the address acceptance of the other half, or the upstream acceptance itself. The bench sweeps every offset against every length, using acceptance and data delays that depend on offset and length. This makes the first half's data land in the very cycle the second half is accepted, as well as before and after it. The bench judges each case by three things: the merged right-aligned result, a single acceptance pulse in the exact cycle the last half is accepted, and a single data pulse with busy low.

// File: rtl/ls_split_pkg.sv
package ls_split_pkg;
    localparam int LINE_BYTES = 16;
    localparam int LINE_W     = LINE_BYTES * 8;
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int LEN_W      = OFF_W + 1;
    localparam int SPAN_BYTES = 2 * LINE_BYTES;

    typedef enum logic {PH_IDLE = 1'b0, PH_RUN = 1'b1} phase_e;

    typedef struct packed {
        phase_e                 phase;
        logic                   is_ld;
        logic                   ackd;
        logic [1:0]             ack;
        logic [1:0]             got;
        logic [1:0][LINE_W-1:0] ldat;
    } split_state_t;
endpackage

// File: rtl/ls_half_map.sv
module ls_half_map
    import ls_split_pkg::*;
#(
    parameter int ADDR_W = 48
) (
    input  logic [ADDR_W-1:0]                  addr_i,
    input  logic [LEN_W-1:0]                   len_i,
    output logic [SPAN_BYTES-1:0]              span_o,
    output logic                               lo_port_o,
    output logic [1:0]                         need_o,
    output logic [1:0][ADDR_W-OFF_W-1:0]       line_o,
    output logic [1:0][LINE_BYTES-1:0]         mask_o
);
    localparam int LINE_AW = ADDR_W - OFF_W;

    logic [SPAN_BYTES-1:0] ones;
    logic [LINE_AW-1:0]    line_first;
    logic [LINE_AW-1:0]    line_next;

    // contiguous run of len enable bits, placed at the byte offset
    assign ones       = ~({SPAN_BYTES{1'b1}} << len_i);
    assign span_o     = ones << addr_i[OFF_W-1:0];
    assign line_first = addr_i[ADDR_W-1:OFF_W];
    assign line_next  = line_first + LINE_AW'(1);
    assign lo_port_o  = addr_i[OFF_W];

    for (genvar p = 0; p < 2; p++) begin : g_half
        logic takes_next;
        assign takes_next = (addr_i[OFF_W] != 1'(p));
        assign line_o[p]  = takes_next ? line_next : line_first;
        assign mask_o[p]  = takes_next ? span_o[SPAN_BYTES-1:LINE_BYTES]
                                       : span_o[LINE_BYTES-1:0];
        assign need_o[p]  = |mask_o[p];
    end
endmodule

// File: rtl/ls_st_align.sv
module ls_st_align
    import ls_split_pkg::*;
(
    input  logic [LINE_W-1:0]       data_i,
    input  logic [OFF_W-1:0]        off_i,
    input  logic                    lo_port_i,
    output logic [1:0][LINE_W-1:0]  data_o
);
    logic [2*LINE_W-1:0] wide;

    assign wide = {LINE_W'(0), data_i} << {off_i, 3'b000};

    for (genvar p = 0; p < 2; p++) begin : g_port
        assign data_o[p] = (lo_port_i == 1'(p)) ? wide[LINE_W-1:0]
                                                : wide[2*LINE_W-1:LINE_W];
    end
endmodule

// File: rtl/ls_ld_merge.sv
module ls_ld_merge
    import ls_split_pkg::*;
(
    input  logic [1:0][LINE_W-1:0]  half_i,
    input  logic                    lo_port_i,
    input  logic [SPAN_BYTES-1:0]   span_i,
    input  logic [OFF_W-1:0]        off_i,
    output logic [LINE_W-1:0]       data_o
);
    logic [LINE_W-1:0]     first_line;
    logic [LINE_W-1:0]     next_line;
    logic [2*LINE_W-1:0]   joined;
    logic [2*LINE_W-1:0]   kept;

    assign first_line = lo_port_i ? half_i[1] : half_i[0];
    assign next_line  = lo_port_i ? half_i[0] : half_i[1];
    assign joined     = {next_line, first_line};

    for (genvar b = 0; b < SPAN_BYTES; b++) begin : g_byte
        assign kept[b*8 +: 8] = span_i[b] ? joined[b*8 +: 8] : 8'h00;
    end

    assign data_o = LINE_W'(kept >> {off_i, 3'b000});
endmodule

// File: rtl/ls_line_splitter.sv
module ls_line_splitter
    import ls_split_pkg::*;
#(
    parameter int ADDR_W = 48
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               up_ld_i,
    input  logic                               up_st_i,
    input  logic [LEN_W-1:0]                   up_len_i,
    input  logic [ADDR_W-1:0]                  up_addr_i,
    input  logic                               up_addr_vld_i,
    output logic                               up_busy_o,
    output logic                               up_addr_ack_o,
    output logic                               up_addr_exc_o,
    output logic [LINE_W-1:0]                  up_ld_data_o,
    output logic                               up_ld_vld_o,
    input  logic [LINE_W-1:0]                  up_st_data_i,
    input  logic                               up_st_vld_i,
    output logic [1:0]                         dn_ld_o,
    output logic [1:0]                         dn_st_o,
    output logic [1:0]                         dn_addr_vld_o,
    output logic [1:0][ADDR_W-OFF_W-1:0]       dn_line_o,
    output logic [1:0][LINE_BYTES-1:0]         dn_mask_o,
    input  logic [1:0]                         dn_addr_ack_i,
    input  logic [1:0]                         dn_addr_exc_i,
    input  logic [1:0][LINE_W-1:0]             dn_ld_data_i,
    input  logic [1:0]                         dn_ld_vld_i,
    output logic [1:0][LINE_W-1:0]             dn_st_data_o,
    output logic [1:0]                         dn_st_vld_o
);
    split_state_t st_q, st_d;

    logic [SPAN_BYTES-1:0]   span;
    logic                    lo_port;
    logic [1:0]              need;
    logic [1:0]              ack_in, exc_in, data_in;
    logic [1:0]              half_ok, half_got;
    logic [1:0][LINE_W-1:0]  half_dat;
    logic                    run, exc_hit, st_fire;

    ls_half_map #(.ADDR_W(ADDR_W)) u_map (
        .addr_i    (up_addr_i),
        .len_i     (up_len_i),
        .span_o    (span),
        .lo_port_o (lo_port),
        .need_o    (need),
        .line_o    (dn_line_o),
        .mask_o    (dn_mask_o)
    );

    ls_st_align u_st_align (
        .data_i    (up_st_data_i),
        .off_i     (up_addr_i[OFF_W-1:0]),
        .lo_port_i (lo_port),
        .data_o    (dn_st_data_o)
    );

    ls_ld_merge u_ld_merge (
        .half_i    (half_dat),
        .lo_port_i (lo_port),
        .span_i    (span),
        .off_i     (up_addr_i[OFF_W-1:0]),
        .data_o    (up_ld_data_o)
    );

    assign run = (st_q.phase == PH_RUN);

    for (genvar p = 0; p < 2; p++) begin : g_half
        assign dn_ld_o[p]       = run & st_q.is_ld & need[p] & ~st_q.got[p];
        assign dn_st_o[p]       = run & ~st_q.is_ld & need[p];
        assign dn_addr_vld_o[p] = (dn_ld_o[p] | dn_st_o[p]) & up_addr_vld_i;
        assign ack_in[p]        = dn_addr_vld_o[p] & dn_addr_ack_i[p];
        assign exc_in[p]        = dn_addr_vld_o[p] & dn_addr_exc_i[p];
        assign data_in[p]       = dn_ld_o[p] & dn_ld_vld_i[p];
        assign half_ok[p]       = ~need[p] | st_q.ack[p] | ack_in[p];
        assign half_got[p]      = ~need[p] | st_q.got[p] | data_in[p];
        assign half_dat[p]      = st_q.got[p] ? st_q.ldat[p] : dn_ld_data_i[p];
        assign dn_st_vld_o[p]   = st_fire & need[p];

        // R1: a port only ever carries lines of its own parity
        a_r1_line_parity: assert property (@(posedge clk) disable iff (!rst_n)
            dn_addr_vld_o[p] |-> (dn_line_o[p][0] == 1'(p)));
        // R2: an empty half never raises its address valid
        a_r2_empty_half_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (dn_mask_o[p] == '0) |-> !dn_addr_vld_o[p]);
        // R8: a half's load request falls after its data returns
        a_r8_drop_after_data: assert property (@(posedge clk) disable iff (!rst_n)
            (dn_ld_o[p] && dn_ld_vld_i[p]) |=> !dn_ld_o[p]);
    end

    assign exc_hit       = |exc_in;
    assign up_addr_exc_o = exc_hit;
    assign up_addr_ack_o = run & up_addr_vld_i & ~st_q.ackd & (&half_ok) & ~exc_hit;
    assign up_ld_vld_o   = run & st_q.is_ld & st_q.ackd & (&half_got) & ~exc_hit;
    assign st_fire       = run & ~st_q.is_ld & st_q.ackd & up_st_vld_i;
    assign up_busy_o     = run ? ~(exc_hit | up_ld_vld_o) : (up_ld_i | up_st_i);

    always_comb begin
        st_d = st_q;
        case (st_q.phase)
            PH_IDLE: begin
                if (up_ld_i | up_st_i) begin
                    st_d.phase = PH_RUN;
                    st_d.is_ld = up_ld_i;
                    st_d.ackd  = 1'b0;
                    st_d.ack   = 2'b00;
                    st_d.got   = 2'b00;
                end
            end
            default: begin
                if (exc_hit | up_ld_vld_o | st_fire) begin
                    st_d.phase = PH_IDLE;
                end else begin
                    st_d.ackd = st_q.ackd | up_addr_ack_o;
                    st_d.ack  = st_q.ack | ack_in;
                    for (int p = 0; p < 2; p++) begin
                        if (data_in[p]) begin
                            st_d.got[p]  = 1'b1;
                            st_d.ldat[p] = dn_ld_data_i[p];
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: upstream acceptance is a single-cycle pulse
    a_r4_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        up_addr_ack_o |=> !up_addr_ack_o);
    // R5: exception ends the request in its own cycle
    a_r5_exc_busy_low: assert property (@(posedge clk) disable iff (!rst_n)
        up_addr_exc_o |-> !up_busy_o);
    // R5: outgoing requests are withdrawn after an exception
    a_r5_exc_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
        up_addr_exc_o |=> (dn_ld_o == 2'b00) && (dn_st_o == 2'b00));
    // R6: load result pulse drops busy and never coincides with acceptance
    a_r6_ld_busy_low: assert property (@(posedge clk) disable iff (!rst_n)
        up_ld_vld_o |-> (!up_busy_o && !up_addr_ack_o));
    // R7: store pulse keeps busy, outgoing store requests end next cycle
    a_r7_st_tail: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_st_vld_o != 2'b00) |-> up_busy_o);
    a_r7_st_release: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_st_vld_o != 2'b00) |=> (dn_st_o == 2'b00));
endmodule

// File: tb/ls_line_splitter_bench.sv
module ls_line_splitter_bench;
    localparam int PERIOD = 10;
    localparam int AW     = 48;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic up_ld = 0, up_st = 0, up_avld = 0, up_stv = 0;
    logic [4:0] up_len = 5'd1;
    logic [AW-1:0] up_addr = '0;
    logic [127:0] up_std = '0;
    logic [1:0] dn_aack = 0, dn_aexc = 0, dn_lvld = 0;
    logic [1:0][127:0] dn_ldat = '0;

    logic up_busy, up_ack, up_exc, up_lv;
    logic [127:0] up_ldd;
    logic [1:0] dn_ld, dn_st, dn_av, dn_sv;
    logic [1:0][AW-5:0] dn_line;
    logic [1:0][15:0] dn_mask;
    logic [1:0][127:0] dn_sd;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #(PERIOD/2) clk = ~clk;

    ls_line_splitter #(.ADDR_W(AW)) u_ls_line_splitter (
        .clk(clk), .rst_n(rst_n),
        .up_ld_i(up_ld), .up_st_i(up_st), .up_len_i(up_len), .up_addr_i(up_addr),
        .up_addr_vld_i(up_avld), .up_busy_o(up_busy), .up_addr_ack_o(up_ack),
        .up_addr_exc_o(up_exc), .up_ld_data_o(up_ldd), .up_ld_vld_o(up_lv),
        .up_st_data_i(up_std), .up_st_vld_i(up_stv),
        .dn_ld_o(dn_ld), .dn_st_o(dn_st), .dn_addr_vld_o(dn_av), .dn_line_o(dn_line),
        .dn_mask_o(dn_mask), .dn_addr_ack_i(dn_aack), .dn_addr_exc_i(dn_aexc),
        .dn_ld_data_i(dn_ldat), .dn_ld_vld_i(dn_lvld),
        .dn_st_data_o(dn_sd), .dn_st_vld_o(dn_sv)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
        return a[7:0] * 8'd5 + a[15:8] + 8'd17;
    endfunction

    function automatic logic [7:0] src_byte(input int i, input int seed);
        return 8'((i * 29 + seed) & 255);
    endfunction

    function automatic logic [AW-5:0] exp_line(input logic [AW-1:0] a, input int p);
        logic [AW-5:0] l;
        l = a[AW-1:4];
        return (l[0] == 1'(p)) ? l : l + 1'b1;
    endfunction

    function automatic logic [15:0] exp_mask(input logic [AW-1:0] a, input int len,
                                             input logic [AW-5:0] line);
        logic [15:0] m;
        logic [AW:0] ba;
        for (int k = 0; k < 16; k++) begin
            ba   = {1'b0, line, 4'(k)};
            m[k] = (ba >= {1'b0, a}) && (ba < ({1'b0, a} + (AW+1)'(len)));
        end
        return m;
    endfunction

    function automatic logic [127:0] line_data(input logic [AW-5:0] line);
        logic [127:0] d;
        for (int k = 0; k < 16; k++) d[k*8 +: 8] = mem_byte({line, 4'(k)});
        return d;
    endfunction

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // drive a load; half p accepts after acc[p] valid cycles, returns data xtra[p] later
    task automatic run_load(input logic [AW-1:0] a, input int len, input int acc0,
                            input int acc1, input int x0, input int x1,
                            input int av, input int excp);
        int cnt[2], accv[2], xv[2];
        bit acked[2], given[2], given_prev[2], seen[2], nexp[2];
        bit bad1, bad2, bad4, bad8, done, ackseen, allnow;
        int cyc;
        logic [127:0] expd;
        accv[0] = acc0; accv[1] = acc1; xv[0] = x0; xv[1] = x1;
        bad1 = 0; bad2 = 0; bad4 = 0; bad8 = 0; done = 0; ackseen = 0; cyc = 0;
        for (int p = 0; p < 2; p++) begin
            cnt[p] = 0; acked[p] = 0; given[p] = 0; seen[p] = 0;
            nexp[p] = (exp_mask(a, len, exp_line(a, p)) != 0);
        end
        for (int i = 0; i < 16; i++)
            expd[i*8 +: 8] = (i < len) ? mem_byte(a + AW'(i)) : 8'h00;
        up_ld = 1; up_len = 5'(len); up_addr = a;
        while (!done && cyc < 60) begin
            @(negedge clk);
            up_avld = (cyc >= av);
            dn_aack = 0; dn_aexc = 0; dn_lvld = 0;
            #1;
            if (cyc == 0) chk(up_busy == 1'b1, "R3", "busy on request", 128'(up_busy), 128'(1));
            for (int p = 0; p < 2; p++) begin
                given_prev[p] = given[p];
                if ((dn_ld[p] || dn_st[p] || dn_av[p]) && !nexp[p]) bad2 = 1;
                if (given_prev[p] && dn_ld[p]) bad8 = 1;
                if (dn_av[p]) begin
                    if (!seen[p]) begin
                        seen[p] = 1;
                        if (dn_line[p] != exp_line(a, p) ||
                            dn_mask[p] != exp_mask(a, len, exp_line(a, p))) bad1 = 1;
                    end
                    if (cnt[p] == accv[p]) begin
                        if (excp == p) dn_aexc[p] = 1;
                        else begin dn_aack[p] = 1; acked[p] = 1; end
                    end else if (acked[p] && cnt[p] == accv[p] + 1 + xv[p] && dn_ld[p]) begin
                        dn_lvld[p] = 1; dn_ldat[p] = line_data(dn_line[p]); given[p] = 1;
                    end
                    cnt[p]++;
                end
            end
            #1;
            allnow = (acked[0] || !nexp[0]) && (acked[1] || !nexp[1]);
            if (excp < 0 && up_ack != (allnow && !ackseen)) bad4 = 1;
            if (up_ack) ackseen = 1;
            if (up_exc) begin
                done = 1;
                chk(excp >= 0 && up_busy == 1'b0 && !up_lv, "R5", "exception pulse, busy low",
                    {126'd0, up_busy, up_lv}, 128'd0);
            end else if (up_lv) begin
                done = 1;
                chk(up_ldd == expd, "R6", "load result", up_ldd, expd);
                chk(up_busy == 1'b0 && ackseen && excp < 0 &&
                    (given[0] || !nexp[0]) && (given[1] || !nexp[1]),
                    "R6", "load pulse timing", 128'(up_busy), 128'd0);
            end
            cyc++;
        end
        if (!done) chk(1'b0, excp >= 0 ? "R5" : "R6", "request never ended", 128'(cyc), 128'd0);
        chk(!bad1, "R1", "line/mask per port", {dn_mask[1], dn_mask[0]}, 128'(len));
        chk(!bad2, "R2", "empty half stayed quiet", 128'(bad2), 128'd0);
        if (excp < 0) begin
            chk(!bad4, "R4", "acceptance pulse cycle", 128'(bad4), 128'd0);
            chk(!bad8, "R8", "load request dropped after data", 128'(bad8), 128'd0);
        end
        @(negedge clk);
        up_ld = 0; up_avld = 0; dn_aack = 0; dn_aexc = 0; dn_lvld = 0;
        #1;
        chk(up_busy == 1'b0 && dn_ld == 2'b00 && dn_st == 2'b00, excp >= 0 ? "R5" : "R3",
            "idle after end", {125'd0, up_busy, dn_ld}, 128'd0);
    endtask

    task automatic run_store(input logic [AW-1:0] a, input int len, input int acc0,
                             input int acc1, input int av, input int seed);
        int cnt[2], accv[2];
        bit nexp[2], bad2, done, ackseen, okd;
        int cyc;
        logic [15:0] em;
        logic [AW-1:0] ba;
        accv[0] = acc0; accv[1] = acc1;
        bad2 = 0; done = 0; ackseen = 0; cyc = 0;
        for (int p = 0; p < 2; p++) begin
            cnt[p] = 0;
            nexp[p] = (exp_mask(a, len, exp_line(a, p)) != 0);
        end
        for (int i = 0; i < 16; i++) up_std[i*8 +: 8] = src_byte(i, seed);
        up_st = 1; up_len = 5'(len); up_addr = a;
        while (!done && cyc < 60) begin
            @(negedge clk);
            up_avld = (cyc >= av);
            dn_aack = 0;
            up_stv = ackseen;
            #1;
            if (cyc == 0) chk(up_busy == 1'b1, "R3", "busy on store request", 128'(up_busy), 128'(1));
            for (int p = 0; p < 2; p++) begin
                if ((dn_st[p] || dn_av[p] || dn_ld[p]) && !nexp[p]) bad2 = 1;
                if (dn_av[p]) begin
                    if (cnt[p] == accv[p]) dn_aack[p] = 1;
                    cnt[p]++;
                end
            end
            #1;
            if (up_stv) begin
                done = 1;
                chk(dn_sv == {nexp[1], nexp[0]} && up_busy == 1'b1, "R7", "store pulse fan-out",
                    {125'd0, up_busy, dn_sv}, {125'd0, 1'b1, nexp[1], nexp[0]});
                for (int p = 0; p < 2; p++) begin
                    if (nexp[p]) begin
                        em = exp_mask(a, len, exp_line(a, p));
                        okd = (dn_mask[p] == em);
                        for (int k = 0; k < 16; k++) begin
                            ba = {exp_line(a, p), 4'(k)};
                            if (em[k] && dn_sd[p][k*8 +: 8] != src_byte(int'(ba - a), seed)) okd = 0;
                        end
                        chk(okd, "R7", "store bytes placed", dn_sd[p], 128'(em));
                    end
                end
            end
            if (up_ack) ackseen = 1;
            cyc++;
        end
        if (!done) chk(1'b0, "R7", "store never completed", 128'(cyc), 128'd0);
        chk(!bad2, "R2", "empty half stayed quiet on store", 128'(bad2), 128'd0);
        @(negedge clk);
        up_st = 0; up_avld = 0; up_stv = 0; dn_aack = 0;
        #1;
        chk(up_busy == 1'b0 && dn_st == 2'b00, "R7", "busy low after store pulse",
            {125'd0, up_busy, dn_st}, 128'd0);
    endtask

    initial begin
        logic [AW-1:0] bases[3];
        bases[0] = 48'h0000_1234_5600;
        bases[1] = 48'h0000_1234_5610;
        bases[2] = 48'h0000_0FFF_FFF0;
        repeat (3) @(negedge clk);
        #1;
        chk(up_busy == 1'b0 && dn_ld == 2'b00 && dn_st == 2'b00 && !up_ack && !up_lv,
            "R3", "reset state", {125'd0, up_busy, dn_ld}, 128'd0);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        #1;
        chk(up_busy == 1'b0, "R3", "idle busy low", 128'(up_busy), 128'd0);
        for (int off = 0; off < 16; off++) begin
            for (int len = 1; len <= 16; len++) begin
                logic [AW-1:0] a;
                a = bases[(off + len) % 3] + AW'(off);
                run_load(a, len, off % 3, len % 4, (off + len) % 2, len % 3, len % 2, -1);
                run_store(a, len, len % 3, off % 2, off % 2, off * 7 + len);
            end
        end
        run_load(bases[0] + 48'd14, 8, 2, 0, 0, 0, 0, 0);
        run_load(bases[1] + 48'd12, 9, 0, 2, 0, 0, 1, 1);
        run_load(bases[2] + 48'd3, 4, 0, 1, 0, 0, 0, 1);
        run_load(bases[0] + 48'd5, 3, 1, 0, 0, 0, 0, 0);
        finish_up();
    end

    initial begin
        #(PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_up();
    end
endmodule